// File: doc/BRIEF.md
# Shadowed Peripheral Register File

This block keeps a local image of a serially attached peripheral's configuration space: 31 words of 16 bits, with one dirty flag per word. The host can overwrite a whole word, which is forwarded to the device at once. It can also merge a bit field into a word, which only updates the local image and flags the word for a later flush. Reads are answered from the local image. Index 31 is a live readback location that always goes to the device.

A commit request flushes every flagged word to the device, lowest index first, through a request/acknowledge port towards a serial master. The master handles the wire protocol. While a flush runs, the block raises `busy` and holds off further host requests, so the set of flagged words cannot change under the flush. The reset image comes from a formula by default, or from a flat parameter vector when one is supplied.

Top module: `shadow_regfile`

## Requirements
- R1: On reset, word i (0..30) holds the low 16 bits of (i × 0x0123) XOR 0x5A00. All 31 dirty flags are set, `host_ready` is 1, `busy` is 0 and `dev_req` is 0, so the first commit sends all 31 words.
- R2: A field write (`host_op` = 1) uses a 4-bit offset and a 4-bit length code, where the length is the code plus one. It replaces only bits [offset, offset+length-1] of the word with the value's low bits. Field bits that would land above bit 15 are dropped, and the other bits keep their value. The write causes no device traffic.
- R3: A field write always sets the word's dirty flag, even when the merged word equals the old one.
- R4: A full write (`host_op` = 0) stores the value and issues one device request with `dev_write` = 1 carrying the index and the value. It clears that word's dirty flag when the request is acknowledged. `host_ready` stays low until then.
- R5: A commit (`host_op` = 3) sends exactly the dirty words, in ascending index order, each with its cached value and `dev_write` = 1. Each flag is cleared on that word's acknowledge.
- R6: `busy` goes high in the cycle after a commit is accepted and falls after the last dirty word has been acknowledged. `host_ready` is low while `busy` is high. A request held during a flush is taken after the flush and is not part of it.
- R7: A read (`host_op` = 2) of a clean word raises `rd_valid` with the cached value in the cycle after acceptance, with no device request.
- R8: A read of a dirty word issues a device read (`dev_write` = 0) and discards the returned data. It returns the cached value and leaves the word dirty.
- R9: A read of index 31 always issues a device read and returns `dev_rdata`. The value is never cached.
- R10: Full or field writes to index 31 are ignored: they cause no device traffic and change no cached word or flag.
- R11: While `dev_req` is high and not yet acknowledged, `dev_req`, `dev_write`, `dev_addr` and `dev_wdata` hold steady. The request drops after the cycle in which `dev_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host request present |
| host_op | input | 2 | 0 full write, 1 field write, 2 read, 3 commit |
| host_idx | input | 5 | Word index, 31 is readback |
| host_off | input | 4 | Field offset (lowest bit of the field) |
| host_len | input | 4 | Field length minus one |
| host_data | input | 16 | Write value or field value |
| host_ready | output | 1 | Request accepted when high together with host_valid |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | 16 | Read result |
| busy | output | 1 | Commit flush in progress |
| dev_req | output | 1 | Request to the serial master |
| dev_write | output | 1 | 1 write, 0 read |
| dev_addr | output | 5 | Device word index |
| dev_wdata | output | 16 | Device write data |
| dev_ack | input | 1 | Serial master completion, one cycle |
| dev_rdata | input | 16 | Device read data, valid with dev_ack |

## Verification
A host field write and a running commit flush can collide. The flush owns the dirty flags, and a field write would set one of them while the scan is still walking the flags. The bench provokes this by presenting a field write to an already dirty word in the cycle after the commit is accepted and holding `host_valid` through the flush. It then judges that the flush sent only the words that were dirty at the commit, with their old values. The held write must be taken only after `busy` falls, and a second commit must send that word alone with the merged value.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

   typedef enum logic [1:0] {
      OP_FULL   = 2'd0,
      OP_FIELD  = 2'd1,
      OP_READ   = 2'd2,
      OP_COMMIT = 2'd3
   } host_op_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_WWAIT,
      S_RWAIT,
      S_CSCAN,
      S_CWAIT
   } ctrl_state_e;

   // formula used for the reset image when no explicit vector is supplied
   function automatic logic [31:0] boot_word(input int unsigned i);
      return (i * 32'h0000_0123) ^ 32'h0000_5A00;
   endfunction

endpackage

// File: rtl/shreg_store.sv
module shreg_store #(
   parameter int NREG = 31,
   parameter int DW = 16,
   parameter int IW = 5,
   parameter int OW = 4,
   parameter int LW = 4,
   parameter bit USE_INIT = 1'b0,
   parameter logic [NREG*DW-1:0] INIT = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic full_en,
   input  logic fld_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic [OW-1:0] fld_off,
   input  logic [LW-1:0] fld_len,
   input  logic clr_en,
   input  logic [IW-1:0] clr_idx,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_word,
   input  logic [IW-1:0] scan_idx,
   output logic [DW-1:0] scan_word,
   output logic [NREG-1:0] dirty
);
   localparam int MW = 2 * DW;
   localparam logic [IW-1:0] LAST = IW'(NREG - 1);

   logic [DW-1:0] boot [NREG];
   logic [DW-1:0] mem [NREG];

   genvar g;
   generate
      for (g = 0; g < NREG; g++) begin : g_boot
         if (USE_INIT) begin : g_vec
            assign boot[g] = INIT[g*DW +: DW];
         end else begin : g_fml
            assign boot[g] = DW'(shreg_pkg::boot_word(g));
         end
      end
   endgenerate

   // field merge: build the mask wide, then keep only the word's bits
   int flen;
   logic [MW-1:0] ones_w, mask_w, ins_w;
   logic [DW-1:0] old_word, merged;
   always_comb begin
      flen   = int'(fld_len) + 1;
      ones_w = (MW'(1) << flen) - MW'(1);
      mask_w = ones_w << fld_off;
      ins_w  = (MW'(wr_data) & ones_w) << fld_off;
      old_word = (wr_idx <= LAST) ? mem[wr_idx] : '0;
      merged = (old_word & ~mask_w[DW-1:0]) | ins_w[DW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) mem[i] <= boot[i];
         dirty <= '1;
      end else begin
         if (full_en && wr_idx <= LAST) mem[wr_idx] <= wr_data;
         if (fld_en && wr_idx <= LAST) begin
            mem[wr_idx]   <= merged;
            dirty[wr_idx] <= 1'b1;
         end
         if (clr_en && clr_idx <= LAST) dirty[clr_idx] <= 1'b0;
      end
   end

   assign rd_word   = (rd_idx <= LAST) ? mem[rd_idx] : '0;
   assign scan_word = (scan_idx <= LAST) ? mem[scan_idx] : '0;

   p_field_dirty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fld_en && wr_idx <= LAST |=> dirty[$past(wr_idx)]);
   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en && !fld_en && clr_idx <= LAST |=> !dirty[$past(clr_idx)]);

endmodule

// File: rtl/shreg_pick.sv
module shreg_pick #(
   parameter int NREG = 31,
   parameter int IW = 5
) (
   input  logic [NREG-1:0] dirty,
   output logic any,
   output logic [IW-1:0] idx
);
   // lowest set flag wins
   always_comb begin
      any = |dirty;
      idx = '0;
      for (int i = NREG - 1; i >= 0; i--) begin
         if (dirty[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/shreg_ctrl.sv
module shreg_ctrl #(
   parameter int NREG = 31,
   parameter int DW = 16,
   parameter int IW = 5,
   parameter int RB_IDX = 31
) (
   input  logic clk,
   input  logic rst_n,
   input  logic host_valid,
   input  logic [1:0] host_op,
   input  logic [IW-1:0] host_idx,
   input  logic [DW-1:0] host_data,
   output logic host_ready,
   output logic rd_valid,
   output logic [DW-1:0] rd_data,
   output logic busy,
   output logic full_en,
   output logic fld_en,
   output logic clr_en,
   output logic [IW-1:0] cache_idx,
   input  logic [DW-1:0] rd_word,
   input  logic [DW-1:0] scan_word,
   input  logic [NREG-1:0] dirty,
   input  logic pick_any,
   input  logic [IW-1:0] pick_idx,
   output logic dev_req,
   output logic dev_write,
   output logic [IW-1:0] dev_addr,
   output logic [DW-1:0] dev_wdata,
   input  logic dev_ack,
   input  logic [DW-1:0] dev_rdata
);
   import shreg_pkg::*;

   localparam logic [IW-1:0] LAST = IW'(NREG - 1);
   localparam logic [IW-1:0] RB   = IW'(RB_IDX);

   ctrl_state_e st;
   logic accept, in_range, is_rb, from_dev, sent_any;
   logic [IW-1:0] last_sent;

   assign host_ready = (st == S_IDLE);
   assign accept     = host_valid && host_ready;
   assign in_range   = host_idx <= LAST;
   assign is_rb      = host_idx == RB;
   assign full_en    = accept && host_op == OP_FULL && in_range;
   assign fld_en     = accept && host_op == OP_FIELD && in_range;
   assign clr_en     = dev_req && dev_ack && dev_write;
   assign cache_idx  = (st == S_IDLE) ? host_idx : dev_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         busy      <= 1'b0;
         rd_valid  <= 1'b0;
         rd_data   <= '0;
         dev_req   <= 1'b0;
         dev_write <= 1'b0;
         dev_addr  <= '0;
         dev_wdata <= '0;
         from_dev  <= 1'b0;
         sent_any  <= 1'b0;
         last_sent <= '0;
      end else begin
         rd_valid <= 1'b0;
         case (st)
            S_IDLE: begin
               sent_any <= 1'b0;
               if (accept) begin
                  case (host_op)
                     OP_FULL: if (in_range) begin
                        dev_req   <= 1'b1;
                        dev_write <= 1'b1;
                        dev_addr  <= host_idx;
                        dev_wdata <= host_data;
                        st        <= S_WWAIT;
                     end
                     OP_READ: begin
                        if (is_rb || (in_range && dirty[host_idx])) begin
                           dev_req   <= 1'b1;
                           dev_write <= 1'b0;
                           dev_addr  <= host_idx;
                           dev_wdata <= '0;
                           from_dev  <= is_rb;
                           st        <= S_RWAIT;
                        end else begin
                           rd_valid <= 1'b1;
                           rd_data  <= rd_word;
                        end
                     end
                     OP_COMMIT: begin
                        busy <= 1'b1;
                        st   <= S_CSCAN;
                     end
                     default: ;
                  endcase
               end
            end
            S_WWAIT: if (dev_ack) begin
               dev_req <= 1'b0;
               st      <= S_IDLE;
            end
            S_RWAIT: if (dev_ack) begin
               dev_req  <= 1'b0;
               rd_valid <= 1'b1;
               rd_data  <= from_dev ? dev_rdata : rd_word;
               st       <= S_IDLE;
            end
            S_CSCAN: begin
               if (pick_any) begin
                  dev_req   <= 1'b1;
                  dev_write <= 1'b1;
                  dev_addr  <= pick_idx;
                  dev_wdata <= scan_word;
                  sent_any  <= 1'b1;
                  last_sent <= pick_idx;
                  st        <= S_CWAIT;
               end else begin
                  busy <= 1'b0;
                  st   <= S_IDLE;
               end
            end
            S_CWAIT: if (dev_ack) begin
               dev_req <= 1'b0;
               st      <= S_CSCAN;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      dev_req && !dev_ack |=> dev_req && $stable(dev_addr) && $stable(dev_wdata) && $stable(dev_write));
   p_req_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      dev_req && dev_ack |=> !dev_req);
   p_busy_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !host_ready);
   p_commit_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy && dev_req |-> dev_write && dirty[dev_addr]);
   p_commit_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      st == S_CSCAN && pick_any && sent_any |-> pick_idx > last_sent);
   p_clean_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      accept && host_op == OP_READ && in_range && !dirty[host_idx] |=> rd_valid && !dev_req);
   p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !in_range && (host_op == OP_FULL || host_op == OP_FIELD) |=> !dev_req && host_ready);

endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile #(
   parameter int NREG = 31,
   parameter int DW = 16,
   parameter int RB_IDX = 31,
   parameter bit USE_INIT = 1'b0,
   parameter logic [NREG*DW-1:0] INIT = '0,
   localparam int IW = $clog2(RB_IDX + 1),
   localparam int OW = $clog2(DW),
   localparam int LW = $clog2(DW)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic host_valid,
   input  logic [1:0] host_op,
   input  logic [IW-1:0] host_idx,
   input  logic [OW-1:0] host_off,
   input  logic [LW-1:0] host_len,
   input  logic [DW-1:0] host_data,
   output logic host_ready,
   output logic rd_valid,
   output logic [DW-1:0] rd_data,
   output logic busy,
   output logic dev_req,
   output logic dev_write,
   output logic [IW-1:0] dev_addr,
   output logic [DW-1:0] dev_wdata,
   input  logic dev_ack,
   input  logic [DW-1:0] dev_rdata
);
   generate
      if (RB_IDX < NREG) begin : g_bad_rb
         $error("readback index must lie above the cached words");
      end
      if (DW < 2 || (1 << LW) != DW) begin : g_bad_dw
         $error("word width must be a power of two");
      end
   endgenerate

   logic full_en, fld_en, clr_en, pick_any;
   logic [IW-1:0] cache_idx, pick_idx;
   logic [DW-1:0] rd_word, scan_word;
   logic [NREG-1:0] dirty;

   shreg_store #(
      .NREG(NREG), .DW(DW), .IW(IW), .OW(OW), .LW(LW),
      .USE_INIT(USE_INIT), .INIT(INIT)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .full_en(full_en), .fld_en(fld_en),
      .wr_idx(host_idx), .wr_data(host_data),
      .fld_off(host_off), .fld_len(host_len),
      .clr_en(clr_en), .clr_idx(dev_addr),
      .rd_idx(cache_idx), .rd_word(rd_word),
      .scan_idx(pick_idx), .scan_word(scan_word),
      .dirty(dirty)
   );

   shreg_pick #(.NREG(NREG), .IW(IW)) u_pick (
      .dirty(dirty), .any(pick_any), .idx(pick_idx)
   );

   shreg_ctrl #(.NREG(NREG), .DW(DW), .IW(IW), .RB_IDX(RB_IDX)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .host_valid(host_valid), .host_op(host_op), .host_idx(host_idx),
      .host_data(host_data), .host_ready(host_ready),
      .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
      .full_en(full_en), .fld_en(fld_en), .clr_en(clr_en),
      .cache_idx(cache_idx), .rd_word(rd_word), .scan_word(scan_word),
      .dirty(dirty), .pick_any(pick_any), .pick_idx(pick_idx),
      .dev_req(dev_req), .dev_write(dev_write), .dev_addr(dev_addr),
      .dev_wdata(dev_wdata), .dev_ack(dev_ack), .dev_rdata(dev_rdata)
   );

endmodule

// File: tb/shadow_regfile_tb.sv
module shadow_regfile_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_valid = 1'b0;
   logic [1:0] host_op = 2'd0;
   logic [4:0] host_idx = '0;
   logic [3:0] host_off = '0;
   logic [3:0] host_len = '0;
   logic [15:0] host_data = '0;
   logic host_ready, rd_valid, busy, dev_req, dev_write;
   logic [15:0] rd_data, dev_wdata;
   logic [4:0] dev_addr;
   logic dev_ack = 1'b0;
   logic [15:0] dev_rdata = '0;

   always #10 clk = ~clk;

   shadow_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_op(host_op),
      .host_idx(host_idx), .host_off(host_off), .host_len(host_len),
      .host_data(host_data), .host_ready(host_ready), .rd_valid(rd_valid),
      .rd_data(rd_data), .busy(busy), .dev_req(dev_req), .dev_write(dev_write),
      .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_ack(dev_ack),
      .dev_rdata(dev_rdata)
   );

   int total = 0, bad = 0;
   bit done = 0;
   logic [15:0] mdl [31];
   bit mdl_dirty [31];
   logic [15:0] dev_mem [32];
   logic [15:0] rb_val = 16'hBEEF;
   logic [20:0] exp_wr [$];
   int dev_reads = 0, dev_writes = 0;
   int wcnt = 0, delay = 0;

   function automatic logic [15:0] boot(input int i);
      return 16'((i * 32'h123) ^ 32'h5A00);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // serial master model: acknowledges after a varying delay, checks writes
   always @(negedge clk) begin
      if (dev_ack) dev_ack = 1'b0;
      else if (dev_req) begin
         if (wcnt >= delay) begin
            wcnt = 0;
            delay = (delay + 1) % 3;
            if (dev_write) begin
               dev_writes++;
               dev_mem[dev_addr] = dev_wdata;
               if (exp_wr.size() == 0)
                  chk(0, "R5 unexpected device write", {dev_addr, dev_wdata}, 0);
               else begin
                  logic [20:0] e;
                  e = exp_wr.pop_front();
                  chk(e == {dev_addr, dev_wdata}, "R4/R5 device write", {dev_addr, dev_wdata}, e);
               end
            end else begin
               dev_reads++;
               dev_rdata = (dev_addr == 5'd31) ? rb_val : dev_mem[dev_addr];
            end
            dev_ack = 1'b1;
         end else wcnt++;
      end
   end

   task automatic issue(input logic [1:0] op, input logic [4:0] idx,
                        input logic [3:0] off, input logic [3:0] lc, input logic [15:0] d);
      host_op = op; host_idx = idx; host_off = off; host_len = lc; host_data = d;
      host_valid = 1'b1;
      while (!host_ready) @(negedge clk);
      @(negedge clk);
      host_valid = 1'b0;
   endtask

   task automatic field_wr(input int idx, input int off, input int lc, input logic [15:0] v);
      if (idx < 31) begin
         logic [31:0] ones, mask;
         ones = (32'h1 << (lc + 1)) - 1;
         mask = ones << off;
         mdl[idx] = (mdl[idx] & ~mask[15:0]) | 16'(((32'(v) & ones) << off));
         mdl_dirty[idx] = 1;
      end
      issue(2'd1, 5'(idx), 4'(off), 4'(lc), v);
   endtask

   task automatic full_wr(input int idx, input logic [15:0] v);
      if (idx < 31) begin
         exp_wr.push_back({5'(idx), v});
         mdl[idx] = v;
         mdl_dirty[idx] = 0;
      end
      issue(2'd0, 5'(idx), 4'd0, 4'd0, v);
      while (!host_ready) @(negedge clk);
   endtask

   task automatic do_read(input int idx, output logic [15:0] v, output int lat);
      issue(2'd2, 5'(idx), 4'd0, 4'd0, 16'd0);
      lat = 1;
      while (!rd_valid && lat < 50) begin @(negedge clk); lat++; end
      v = rd_data;
      @(negedge clk);
   endtask

   task automatic commit_start();
      for (int i = 0; i < 31; i++) begin
         if (mdl_dirty[i]) begin
            exp_wr.push_back({5'(i), mdl[i]});
            mdl_dirty[i] = 0;
         end
      end
      issue(2'd3, 5'd0, 4'd0, 4'd0, 16'd0);
      chk(busy && !host_ready, "R6 busy and stall after commit", {busy, host_ready}, 2'b10);
   endtask

   task automatic commit_wait();
      while (busy) @(negedge clk);
      chk(exp_wr.size() == 0, "R5 all dirty words sent", exp_wr.size(), 0);
   endtask

   initial begin
      int w0, r0, lat;
      logic [15:0] v;
      for (int i = 0; i < 31; i++) begin mdl[i] = boot(i); mdl_dirty[i] = 1; end
      for (int i = 0; i < 32; i++) dev_mem[i] = 16'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(host_ready && !busy && !dev_req && !rd_valid, "R1 reset outputs",
          {host_ready, busy, dev_req, rd_valid}, 4'b1000);

      // R8: dirty read after reset goes to the device, cached value returned
      r0 = dev_reads;
      do_read(3, v, lat);
      chk(v == boot(3), "R8 dirty read returns cache", v, boot(3));
      chk(dev_reads == r0 + 1, "R8 dirty read issues device read", dev_reads, r0 + 1);

      // R1: first commit sends the whole reset image
      w0 = dev_writes;
      commit_start();
      commit_wait();
      chk(dev_writes == w0 + 31, "R1 first commit writes all words", dev_writes - w0, 31);

      // R7: clean read, one cycle, no device traffic
      r0 = dev_reads;
      do_read(7, v, lat);
      chk(v == boot(7), "R7 clean read value", v, boot(7));
      chk(lat == 1 && dev_reads == r0, "R7 clean read latency", lat, 1);

      // R2: field merge with truncated value, then dirty read R8
      field_wr(5, 4, 3, 16'h00FF);
      field_wr(9, 14, 3, 16'h000F);
      field_wr(12, 0, 3, {12'h0, mdl[12][3:0]});   // R3 unchanged value
      r0 = dev_reads;
      do_read(5, v, lat);
      chk(v == mdl[5], "R2 field merge word 5", v, mdl[5]);
      chk(dev_reads == r0 + 1, "R8 dirty read after field write", dev_reads, r0 + 1);
      do_read(9, v, lat);
      chk(v == mdl[9], "R2 field beyond bit 15 dropped", v, mdl[9]);
      w0 = dev_writes;
      commit_start();
      commit_wait();
      chk(dev_writes == w0 + 3, "R3 unchanged field still flushed", dev_writes - w0, 3);

      // R4: full write goes out at once and leaves the word clean
      w0 = dev_writes;
      field_wr(20, 0, 15, 16'h7777);
      full_wr(20, 16'h1234);
      chk(dev_writes == w0 + 1, "R4 full write forwarded", dev_writes - w0, 1);
      r0 = dev_reads;
      do_read(20, v, lat);
      chk(v == 16'h1234 && lat == 1 && dev_reads == r0, "R4 full write leaves word clean", v, 16'h1234);
      w0 = dev_writes;
      commit_start();
      @(negedge clk);
      chk(!busy && host_ready, "R6 empty commit ends", {busy, host_ready}, 2'b01);
      commit_wait();
      chk(dev_writes == w0, "R4 nothing dirty to flush", dev_writes - w0, 0);

      // R9: readback never cached
      rb_val = 16'hBEEF;
      do_read(31, v, lat);
      chk(v == 16'hBEEF, "R9 readback value", v, 16'hBEEF);
      rb_val = 16'h0F0F;
      do_read(31, v, lat);
      chk(v == 16'h0F0F, "R9 readback not cached", v, 16'h0F0F);

      // R10: writes to the readback index are ignored
      w0 = dev_writes;
      full_wr(31, 16'hAAAA);
      field_wr(31, 0, 15, 16'h5555);
      @(negedge clk);
      chk(dev_writes == w0 && !dev_req, "R10 no traffic for index 31", dev_writes - w0, 0);
      do_read(31, v, lat);
      chk(v == 16'h0F0F, "R10 readback unaffected", v, 16'h0F0F);
      commit_start();
      commit_wait();
      chk(dev_writes == w0, "R10 no word flagged", dev_writes - w0, 0);

      // R6: field write held while a flush runs
      field_wr(2, 0, 7, 16'h00C3);
      field_wr(30, 8, 7, 16'h00A5);
      w0 = dev_writes;
      commit_start();
      field_wr(2, 8, 3, 16'h0009);
      chk(exp_wr.size() == 0 && dev_writes == w0 + 2, "R6 held write after flush",
          dev_writes - w0, 2);
      commit_start();
      commit_wait();
      chk(dev_writes == w0 + 3 && dev_mem[2] == mdl[2], "R6 held write flushed next",
          dev_mem[2], mdl[2]);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule